// File: doc/BRIEF.md
# Coherent store upgrade controller

This controller sits between a core's store port and a small coherent cache. When a store hits a line that the cache holds in the shared clean state, the controller does not fetch the line again. It sends a dataless ownership request (CleanUnique) on the read address channel. The interconnect must remove every other cached copy and write any dirty copy back to memory before it answers. The answer carries no line data. When a good response arrives, the controller merges the store bytes into the line it already holds, marks the line unique dirty, and then pulses the read acknowledge.

A store that hits a line the cache already owns (unique clean or unique dirty) completes in the cycle it is presented, with no bus traffic. A store that misses is not handled here. It is flagged as an error in the same cycle. Only one upgrade can be in flight, so the store port stays closed from request issue through the acknowledge cycle. If the response reports an error, the line is left untouched, the response is still acknowledged, and the request is issued again.

The cache array itself is outside the block. The controller drives a lookup index and reads back the tag, state and line data combinationally. It writes a whole line, with its new state, through a one-cycle write strobe. The line states are encoded as 0 invalid, 1 shared clean, 2 unique clean and 3 unique dirty.

Top module: `store_upgrade_ctrl`

## Requirements
- R1: A store that hits a line in state 1 produces exactly one read address request per attempt. The request carries the CleanUnique code 4'b1011 on ar_snoop and the line address with its low log2(LINE_BYTES) bits zero. It is issued without any line read.
- R2: The line written after an upgrade takes byte b from st_data[8b+7:8b] wherever st_be[b] is 1, and keeps byte b of the line data already held in the cache wherever st_be[b] is 0.
- R3: An upgrade writes the line only in the cycle right after a response with r_resp[1]=0, and that write sets the state to 3.
- R4: rack is high for exactly one cycle, in the cycle right after the upgrade write, and st_done is high in that same cycle.
- R5: st_ready is low from the cycle after a store is accepted for upgrade through the rack cycle. It is high again in the following cycle.
- R6: A store that hits a line in state 2 or 3 writes the merged line with state 3 and raises st_done in the same cycle it is presented, and issues no read address request.
- R7: A store that finds state 0 or a tag mismatch raises st_miss in the same cycle. It writes nothing and issues no read address request.
- R8: A response with r_resp[1]=1 causes no line write. It is acknowledged with a one-cycle rack and is followed in the next cycle by a new read address request for the same line.
- R9: Once raised, ar_valid stays high with ar_addr unchanged until ar_ready is seen.
- R10: During and right after reset, ar_valid, rack, wr_en and st_done are low and st_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Controller can take a store |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | LINE_BYTES*8 | Store data, line wide |
| st_be | input | LINE_BYTES | Byte enables, bit b selects byte b |
| st_done | output | 1 | Store completed pulse |
| st_miss | output | 1 | Store rejected, line not present |
| ar_valid | output | 1 | Ownership request valid |
| ar_ready | input | 1 | Interconnect takes the request |
| ar_addr | output | ADDR_W | Line-aligned request address |
| ar_snoop | output | 4 | Transaction code, CleanUnique |
| r_valid | input | 1 | Ownership response valid |
| r_resp | input | 2 | Response status, bit 1 set means error |
| rack | output | 1 | Read acknowledge pulse |
| lk_idx | output | log2(SETS) | Cache set being looked up |
| lk_tag | input | TAG_W | Tag of the looked-up set |
| lk_state | input | 2 | State of the looked-up set |
| lk_data | input | LINE_BYTES*8 | Data of the looked-up set |
| wr_en | output | 1 | Line write strobe |
| wr_idx | output | log2(SETS) | Set written |
| wr_state | output | 2 | New line state |
| wr_data | output | LINE_BYTES*8 | New line data |

## Verification
The bench drives sparse and zero byte-enable masks into lines with distinct old contents. A controller that took data from a response, or wrote the whole line, would then leave the wrong bytes. It varies request and response latency and inserts one or two error responses. These cases catch a write that fires early or on an error, a missing acknowledge or retry, and a state left shared. It also presents hits on owned lines and misses, including a tag mismatch on a valid set. Those expose any stray bus request, a delayed completion, or a write on a miss. Port readiness is watched in every cycle of an upgrade, so a second store accepted mid-flight would show up.

// File: rtl/store_upgrade_ctrl.sv
module store_upgrade_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 4
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        st_valid,
  output logic                                        st_ready,
  input  logic [ADDR_W-1:0]                           st_addr,
  input  logic [LINE_BYTES*8-1:0]                     st_data,
  input  logic [LINE_BYTES-1:0]                       st_be,
  output logic                                        st_done,
  output logic                                        st_miss,
  output logic                                        ar_valid,
  input  logic                                        ar_ready,
  output logic [ADDR_W-1:0]                           ar_addr,
  output logic [3:0]                                  ar_snoop,
  input  logic                                        r_valid,
  input  logic [1:0]                                  r_resp,
  output logic                                        rack,
  output logic [$clog2(SETS)-1:0]                     lk_idx,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-$clog2(SETS)-1:0] lk_tag,
  input  logic [1:0]                                  lk_state,
  input  logic [LINE_BYTES*8-1:0]                     lk_data,
  output logic                                        wr_en,
  output logic [$clog2(SETS)-1:0]                     wr_idx,
  output logic [1:0]                                  wr_state,
  output logic [LINE_BYTES*8-1:0]                     wr_data
);
  localparam int OFS_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFS_W - IDX_W;
  localparam int LINE_W = ADDR_W - OFS_W;
  localparam int DATA_W = LINE_BYTES * 8;
  localparam logic [1:0] ST_INV = 2'd0;
  localparam logic [1:0] ST_SC  = 2'd1;
  localparam logic [1:0] ST_UD  = 2'd3;
  localparam logic [3:0] OP_CLEAN_UNIQUE = 4'b1011;

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_RETRY, S_WRITE, S_ACK} fsm_t;

  fsm_t                  fsm;
  logic [LINE_W-1:0]     sv_line;
  logic [DATA_W-1:0]     sv_data;
  logic [LINE_BYTES-1:0] sv_be;

  logic                  idle;
  logic [LINE_W-1:0]     cur_line;
  logic [DATA_W-1:0]     cur_data;
  logic [LINE_BYTES-1:0] cur_be;
  logic                  hit;
  logic                  local_hit;
  logic                  shared_hit;
  logic                  unused_bits;

  assign idle       = (fsm == S_IDLE);
  assign cur_line   = idle ? st_addr[ADDR_W-1:OFS_W] : sv_line;
  assign cur_data   = idle ? st_data : sv_data;
  assign cur_be     = idle ? st_be : sv_be;
  assign lk_idx     = cur_line[IDX_W-1:0];
  assign hit        = (lk_state != ST_INV) && (lk_tag == cur_line[LINE_W-1:IDX_W]);
  assign local_hit  = idle && st_valid && hit && lk_state[1];
  assign shared_hit = idle && st_valid && hit && (lk_state == ST_SC);
  assign unused_bits = ^{st_addr[OFS_W-1:0], r_resp[0]};

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_merge
    assign wr_data[8*b +: 8] = cur_be[b] ? cur_data[8*b +: 8] : lk_data[8*b +: 8];
  end

  assign wr_en    = local_hit || (fsm == S_WRITE);
  assign wr_idx   = lk_idx;
  assign wr_state = ST_UD;
  assign st_ready = idle;
  assign st_miss  = idle && st_valid && !hit;
  assign st_done  = local_hit || (fsm == S_ACK);
  assign ar_valid = (fsm == S_ISSUE);
  assign ar_addr  = {sv_line, {OFS_W{1'b0}}};
  assign ar_snoop = OP_CLEAN_UNIQUE;
  assign rack     = (fsm == S_ACK) || (fsm == S_RETRY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm     <= S_IDLE;
      sv_line <= '0;
      sv_data <= '0;
      sv_be   <= '0;
    end else begin
      case (fsm)
        S_IDLE: if (shared_hit) begin
          sv_line <= st_addr[ADDR_W-1:OFS_W];
          sv_data <= st_data;
          sv_be   <= st_be;
          fsm     <= S_ISSUE;
        end
        S_ISSUE: if (ar_ready) fsm <= S_WAIT;
        S_WAIT:  if (r_valid)  fsm <= r_resp[1] ? S_RETRY : S_WRITE;
        S_RETRY: fsm <= S_ISSUE;
        S_WRITE: fsm <= S_ACK;
        default: fsm <= S_IDLE;
      endcase
    end
  end
endmodule

module store_upgrade_ctrl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_ready,
  input logic              st_done,
  input logic              ar_valid,
  input logic              ar_ready,
  input logic [ADDR_W-1:0] ar_addr,
  input logic              r_valid,
  input logic [1:0]        r_resp,
  input logic              rack,
  input logic              wr_en
);
  // R3
  write_after_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !st_ready) |-> $past(r_valid && !r_resp[1]));
  // R4
  rack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rack |=> !rack);
  // R4
  rack_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rack && st_done) |-> $past(wr_en));
  // R8
  rack_after_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rack && !st_done) |-> $past(r_valid && r_resp[1]));
  // R8
  retry_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rack && !st_done) |=> ar_valid);
  // R9
  ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && !ar_ready) |=> (ar_valid && $stable(ar_addr)));
  // R5
  busy_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && ar_ready) |=> !st_ready);
endmodule

bind store_upgrade_ctrl store_upgrade_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_ready(st_ready), .st_done(st_done),
  .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
  .r_valid(r_valid), .r_resp(r_resp), .rack(rack), .wr_en(wr_en)
);

// File: tb/test_store_upgrade_ctrl.sv
`timescale 1ns/1ps
module test_store_upgrade_ctrl;
  localparam int ADDR_W = 32;
  localparam int LB     = 64;
  localparam int SETS   = 4;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - $clog2(LB) - IDX_W;
  localparam int DW     = LB * 8;

  // fields: [8:7] initial state, [6] tag matches, [5:4] error responses, [3:2] AR latency, [1:0] R latency
  localparam logic [8:0] VEC [0:7] = '{
    {2'd1, 1'b1, 2'd0, 2'd0, 2'd0},
    {2'd1, 1'b1, 2'd0, 2'd2, 2'd1},
    {2'd1, 1'b1, 2'd1, 2'd0, 2'd0},
    {2'd1, 1'b1, 2'd2, 2'd1, 2'd2},
    {2'd2, 1'b1, 2'd0, 2'd0, 2'd0},
    {2'd3, 1'b1, 2'd0, 2'd1, 2'd0},
    {2'd0, 1'b1, 2'd0, 2'd0, 2'd0},
    {2'd1, 1'b0, 2'd0, 2'd0, 2'd0}
  };

  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic st_valid = 0, st_ready, st_done, st_miss;
  logic [ADDR_W-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [LB-1:0] st_be = '0;
  logic ar_valid, ar_ready = 0, r_valid = 0, rack;
  logic [ADDR_W-1:0] ar_addr;
  logic [3:0] ar_snoop;
  logic [1:0] r_resp = 0;
  logic [IDX_W-1:0] lk_idx, wr_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [1:0] lk_state, wr_state;
  logic [DW-1:0] lk_data, wr_data;
  logic wr_en;

  logic [1:0]       m_state [SETS];
  logic [TAG_W-1:0] m_tag   [SETS];
  logic [DW-1:0]    m_data  [SETS];
  assign lk_tag   = m_tag[lk_idx];
  assign lk_state = m_state[lk_idx];
  assign lk_data  = m_data[lk_idx];
  always @(posedge clk) if (wr_en) begin
    m_state[wr_idx] <= wr_state;
    m_data[wr_idx]  <= wr_data;
  end

  store_upgrade_ctrl i_store_upgrade_ctrl (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be), .st_done(st_done),
    .st_miss(st_miss), .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
    .ar_snoop(ar_snoop), .r_valid(r_valid), .r_resp(r_resp), .rack(rack),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_state(lk_state), .lk_data(lk_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_state(wr_state), .wr_data(wr_data));

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // interconnect model
  int n_ar = 0, errs_left = 0, ar_lat = 0, r_lat = 0;
  logic [ADDR_W-1:0] exp_ar_addr = '0;
  initial begin
    int acnt = 0, rcnt = 0;
    bit pend = 0, hs, av, rf;
    forever begin
      @(negedge clk);
      hs = ar_valid && ar_ready;
      av = ar_valid;
      rf = r_valid;
      if (hs) begin
        chk(ar_addr == exp_ar_addr, "R1 address", ar_addr, exp_ar_addr);
        chk(ar_snoop == 4'b1011, "R1 snoop code", ar_snoop, 4'b1011);
      end
      @(posedge clk); #2;
      ar_ready = 0;
      r_valid = 0;
      if (hs) begin
        pend = 1; rcnt = r_lat; acnt = 0; n_ar++;
      end else if (av && !pend) begin
        if (acnt >= ar_lat) ar_ready = 1; else acnt++;
      end
      if (rf) begin
        pend = 0;
        if (errs_left > 0) errs_left--;
      end else if (pend && !hs) begin
        if (rcnt == 0) begin
          r_valid = 1;
          r_resp = (errs_left > 0) ? 2'b10 : 2'b00;
        end else rcnt--;
      end
    end
  end

  task automatic run_store(input int idx, input logic [1:0] st0, input bit tag_ok, input int errs,
                           input int arl, input int rl, input logic [LB-1:0] be,
                           input logic [DW-1:0] nd, input logic [DW-1:0] od);
    logic [TAG_W-1:0] tg;
    logic [DW-1:0] exp;
    bit miss, loc, done, p_ok, p_err, p_wr, p_av, p_ar;
    logic [ADDR_W-1:0] p_addr;
    int base, wrs, racks;
    tg = TAG_W'(24'h5AC300 + idx);
    for (int b = 0; b < LB; b++) exp[8*b +: 8] = be[b] ? nd[8*b +: 8] : od[8*b +: 8];
    miss = (st0 == 2'd0) || !tag_ok;
    loc  = !miss && st0[1];
    @(posedge clk); #2;
    m_state[idx] = st0;
    m_tag[idx]   = tag_ok ? tg : tg ^ 1'b1;
    m_data[idx]  = od;
    errs_left = errs; ar_lat = arl; r_lat = rl;
    exp_ar_addr = {tg, IDX_W'(idx), 6'h00};
    base = n_ar;
    st_addr = {tg, IDX_W'(idx), 6'h2D};
    st_data = nd; st_be = be; st_valid = 1;
    @(negedge clk);
    if (miss) begin
      chk(st_miss == 1, "R7 miss flag", st_miss, 1);
      chk(wr_en == 0, "R7 no write", wr_en, 0);
    end else if (loc) begin
      chk(wr_en == 1 && st_done == 1, "R6 same-cycle completion", {wr_en, st_done}, 2'b11);
      chk(wr_state == 2'd3, "R6 state", wr_state, 3);
      chk(wr_data == exp, "R6 merged data", wr_data, exp);
    end else begin
      chk(st_ready == 1 && wr_en == 0 && st_done == 0, "R1 no early write", {st_ready, wr_en, st_done}, 3'b100);
    end
    @(posedge clk); #2;
    st_valid = 0;
    if (!miss && !loc) begin
      done = 0; p_ok = 0; p_err = 0; p_wr = 0; p_av = 0; p_ar = 0; p_addr = '0;
      wrs = 0; racks = 0;
      for (int c = 0; c < 400 && !done; c++) begin
        @(negedge clk);
        chk(st_ready == 0, "R5 port closed", st_ready, 0);
        if (p_av && !p_ar)
          chk(ar_valid == 1 && ar_addr == p_addr, "R9 request held", {ar_valid, ar_addr}, {1'b1, p_addr});
        if (p_err) chk(!wr_en && rack && !st_done, "R8 error acknowledged", {wr_en, rack, st_done}, 3'b010);
        if (wr_en) begin
          wrs++;
          chk(p_ok, "R3 write after good response", p_ok, 1);
          chk(wr_state == 2'd3, "R3 state", wr_state, 3);
          chk(wr_data == exp, "R2 merged data", wr_data, exp);
        end
        if (rack) racks++;
        if (st_done) begin
          done = 1;
          chk(rack && p_wr, "R4 rack after write", {rack, p_wr}, 2'b11);
        end
        p_ok = r_valid && !r_resp[1];
        p_err = r_valid && r_resp[1];
        p_wr = wr_en; p_av = ar_valid; p_ar = ar_ready; p_addr = ar_addr;
      end
      chk(done, "R4 completion", done, 1);
      chk(n_ar - base == errs + 1, "R8 request count", n_ar - base, errs + 1);
      chk(wrs == 1, "R3 single write", wrs, 1);
      chk(racks == errs + 1, "R4 rack count", racks, errs + 1);
      @(negedge clk);
      chk(st_ready == 1 && rack == 0, "R5 port reopens", {st_ready, rack}, 2'b10);
      chk(m_state[idx] == 2'd3, "R3 final state", m_state[idx], 3);
      chk(m_data[idx] == exp, "R2 final data", m_data[idx], exp);
    end else begin
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        chk(ar_valid == 0 && wr_en == 0, miss ? "R7 no traffic" : "R6 no traffic", {ar_valid, wr_en}, 0);
      end
      chk(n_ar == base, miss ? "R7 request count" : "R6 request count", n_ar - base, 0);
      if (miss) begin
        chk(m_state[idx] == st0, "R7 state untouched", m_state[idx], st0);
        chk(m_data[idx] == od, "R7 data untouched", m_data[idx], od);
      end else begin
        chk(m_state[idx] == 2'd3, "R6 final state", m_state[idx], 3);
        chk(m_data[idx] == exp, "R6 final data", m_data[idx], exp);
      end
    end
  endtask

  initial begin
    for (int s = 0; s < SETS; s++) begin
      m_state[s] = 0; m_tag[s] = '0; m_data[s] = '0;
    end
    repeat (2) @(negedge clk);
    chk(st_ready == 1 && ar_valid == 0 && rack == 0 && wr_en == 0 && st_done == 0,
        "R10 in reset", {st_ready, ar_valid, rack, wr_en, st_done}, 5'b10000);
    @(posedge clk); #2;
    rst_n = 1;
    @(negedge clk);
    chk(st_ready == 1 && ar_valid == 0 && rack == 0 && wr_en == 0 && st_done == 0,
        "R10 after reset", {st_ready, ar_valid, rack, wr_en, st_done}, 5'b10000);

    for (int i = 0; i < 8; i++) begin
      logic [8:0] v;
      v = VEC[i];
      run_store(i % SETS, v[8:7], v[6], int'(v[5:4]), int'(v[3:2]), int'(v[1:0]),
                (i == 0) ? {LB{1'b1}} : ({16{4'(i + 3)}} ^ 64'h8001_0000_F0F0_0000),
                {16{32'hA5000000 + 32'(i)}}, {16{32'h0F1E2D3C ^ 32'(i)}});
    end

    // zero byte enables, with one error response: line data must come out unchanged
    run_store(2, 2'd1, 1'b1, 1, 2, 1, '0, {16{32'hDEADBEEF}}, {16{32'h13579BDF}});
    // single high byte on an owned dirty line
    run_store(3, 2'd3, 1'b1, 0, 0, 0, 64'h8000_0000_0000_0000, {16{32'hFFFFFFFF}}, '0);
    // single low byte upgrade, long latencies
    run_store(1, 2'd1, 1'b1, 0, 3, 3, 64'h1, {16{32'h000000C3}}, {16{32'h11111111}});

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule